// File: doc/BRIEF.md
# Keyboard Scancode Translator and Command Responder

This block sits in front of the receive byte queue of a keyboard channel. It has two input streams. The first carries scancodes from a keyboard model that uses PC-style codes. A scancode goes through one of two 128-entry mapping tables. The table is chosen by a one-shot escape code, 0xE0. The release flag in bit 7 is kept, and the mapped byte goes out on a push stream into the queue.

The second input stream carries command bytes written by the host. A reset-identify command or a layout query makes the block request a queue flush and then push a fixed reply. A set-indicators command makes the block swallow the parameter byte that follows it. Caps-lock and num-lock events pass through a two-bit toggle state per key. That state drops alternate presses and releases, so a host sees each lock key as a single press and release pair per state change.

All three data paths are valid/ready streams:
- An input byte is taken on a cycle where both its valid and its ready are high.
- An output byte is consumed on a cycle where `push_valid` and `push_ready` are both high.
- Once `push_valid` is raised, it stays high with `push_data` unchanged until the byte is consumed.
- The block works on one input byte or one reply at a time. While a translated byte or a reply is outstanding, both input readies are low.
- When both inputs are offered in the same cycle, the command wins.

`q_clear` is a plain one-cycle pulse to the queue.

Top module: `kbd_xlat`

## Requirements
- R1: Command byte 0x01 (reset-identify) is answered in order. First, `q_clear` pulses high for exactly the cycle after the command is taken. Then the bytes 0xFF, 0x04, 0x7F are pushed, one per consumed push.
- R2: Command bytes 0x07 and 0x0F (layout query) produce a `q_clear` pulse in the cycle after acceptance, followed by the pushed bytes 0xFE, 0x00.
- R3: Any other command byte is taken and ignored: no `q_clear` and no push.
- R4: Command byte 0x0E (set indicators) pushes nothing and makes the next command byte be ignored whatever its value. The following command byte is decoded normally again.
- R5: Scancode 0xE0 pushes nothing and arms a prefix flag. The next scancode that is translated uses the alternate table, and the flag is then cleared.
- R6: A translated scancode c is pushed as table[c[6:0]] OR (c & 0x80). With default parameters, primary entry i is (37*i+5) mod 128 and alternate entry i is (11*i+3) mod 128.
- R7: Caps lock (press 0x3A, release 0xBA) and num lock (press 0x45, release 0xC5) each keep a two-bit state, reset to 0. A press toggles bit 0 and is dropped when the new state is 2. A release toggles bit 1 and is dropped when the new state is 3. A dropped event pushes nothing and leaves the prefix flag unchanged. An event that is not dropped is translated per R5/R6.
- R8: From the cycle after a reply-producing command is taken until its last byte is consumed, `cmd_ready` and `scan_ready` are low.
- R9: While `push_valid` is high and `push_ready` is low, `push_valid` stays high and `push_data` stays stable in the next cycle.
- R10: At most one input byte is taken per cycle. `scan_ready` is low while a translated byte waits and while `cmd_valid` is high.
- R11: After reset, `push_valid` and `q_clear` are low, both readies are high, and the prefix flag, lock states and indicator mode are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_valid | input | 1 | Scancode offered |
| scan_ready | output | 1 | Scancode can be taken |
| scan_code | input | 8 | Incoming scancode, bit 7 marks a release |
| cmd_valid | input | 1 | Host command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_byte | input | 8 | Host command byte |
| push_valid | output | 1 | Byte offered to the queue |
| push_ready | input | 1 | Queue consumes the offered byte |
| push_data | output | 8 | Byte for the queue |
| q_clear | output | 1 | One-cycle request to empty the queue |

## Verification
The properties reason only about accepted handshakes. An offer that is never accepted is therefore harmless, and a producer may withdraw valid. The prefix property assumes the escape code differs from the four lock codes, which the default parameters guarantee. The stimulus holds each valid high until its ready is seen, and it offers both inputs together only in one deliberate priority check. It varies `push_ready` between always-on, a one-in-three stall pattern and a full stall, so that a reply and a pending scancode are both held against back-pressure.

// File: rtl/kbd_xlat_pkg.sv
`timescale 1ns/1ps
package kbd_xlat_pkg;
  localparam int unsigned IDX_W     = 7;
  localparam int unsigned CODE_W    = IDX_W + 1;
  localparam int unsigned MAP_DEPTH = 1 << IDX_W;
  localparam int unsigned MAP_BITS  = MAP_DEPTH * CODE_W;
  localparam int unsigned RSP_IDX_W = 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {PH_IDLE, PH_CLEAR, PH_EMIT} phase_e;
  typedef enum logic {RSP_IDENT, RSP_LAYOUT} rsp_e;

  localparam code_t CMD_IDENT    = 8'h01;
  localparam code_t CMD_LEDS     = 8'h0E;
  localparam code_t CMD_LAYOUT_A = 8'h07;
  localparam code_t CMD_LAYOUT_B = 8'h0F;

  // Arithmetic default map: entry i = (mul*i + add) mod MAP_DEPTH
  function automatic logic [MAP_BITS-1:0] build_map(int unsigned mul, int unsigned add);
    logic [MAP_BITS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAP_DEPTH; i++) begin
      m[i*CODE_W +: CODE_W] = CODE_W'((i * mul + add) % MAP_DEPTH);
    end
    return m;
  endfunction

  function automatic code_t rsp_byte(rsp_e kind, logic [RSP_IDX_W-1:0] idx);
    code_t b;
    b = '0;
    if (kind == RSP_IDENT) begin
      case (idx)
        2'd0:    b = 8'hFF;
        2'd1:    b = 8'h04;
        default: b = 8'h7F;
      endcase
    end else begin
      b = (idx == 2'd0) ? 8'hFE : 8'h00;
    end
    return b;
  endfunction

  function automatic logic [RSP_IDX_W-1:0] rsp_last(rsp_e kind);
    return (kind == RSP_IDENT) ? RSP_IDX_W'(2) : RSP_IDX_W'(1);
  endfunction
endpackage

// File: rtl/kbd_lock_gate.sv
`timescale 1ns/1ps
module kbd_lock_gate
  import kbd_xlat_pkg::*;
#(
  parameter int unsigned           NKEYS       = 2,
  parameter logic [NKEYS*8-1:0]    PRESS_CODES = {8'd69, 8'd58}
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  code_t code,
  output logic  is_lock,
  output logic  drop
);
  localparam code_t REL_FLAG = code_t'(1) << IDX_W;

  logic [NKEYS-1:0] drop_k;
  logic [NKEYS-1:0] hit_k;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    localparam code_t PRESS = PRESS_CODES[k*8 +: 8];
    localparam code_t REL   = PRESS | REL_FLAG;
    logic [1:0] st;
    logic [1:0] st_press;
    logic [1:0] st_rel;
    logic       is_press;
    logic       is_rel;

    assign is_press  = (code == PRESS);
    assign is_rel    = (code == REL);
    assign st_press  = st ^ 2'b01;
    assign st_rel    = st ^ 2'b10;
    assign hit_k[k]  = is_press | is_rel;
    assign drop_k[k] = (is_press && st_press == 2'd2) || (is_rel && st_rel == 2'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= 2'd0;
      end else if (fire) begin
        if (is_press)    st <= st_press;
        else if (is_rel) st <= st_rel;
      end
    end
  end

  assign is_lock = |hit_k;
  assign drop    = |drop_k;
endmodule

// File: rtl/kbd_scan_stage.sv
`timescale 1ns/1ps
module kbd_scan_stage
  import kbd_xlat_pkg::*;
#(
  parameter logic [MAP_BITS-1:0] PRI_MAP     = build_map(37, 5),
  parameter logic [MAP_BITS-1:0] ALT_MAP     = build_map(11, 3),
  parameter code_t               PREFIX_CODE = 8'hE0,
  parameter int unsigned         NKEYS       = 2,
  parameter logic [NKEYS*8-1:0]  LOCK_PRESS  = {8'd69, 8'd58}
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_fire,
  input  code_t in_code,
  input  logic  out_take,
  output logic  out_full,
  output code_t out_data
);
  logic              prefix_q;
  logic              lock_hit;
  logic              lock_drop;
  logic              is_prefix;
  logic [IDX_W-1:0]  idx;
  code_t             pri_val;
  code_t             alt_val;
  code_t             mapped;

  kbd_lock_gate #(
    .NKEYS       (NKEYS),
    .PRESS_CODES (LOCK_PRESS)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (in_fire),
    .code    (in_code),
    .is_lock (lock_hit),
    .drop    (lock_drop)
  );

  assign is_prefix = (in_code == PREFIX_CODE) && !lock_hit;
  assign idx       = in_code[IDX_W-1:0];
  assign pri_val   = PRI_MAP[idx*CODE_W +: CODE_W];
  assign alt_val   = ALT_MAP[idx*CODE_W +: CODE_W];
  assign mapped    = (prefix_q ? alt_val : pri_val) | {in_code[CODE_W-1], {IDX_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prefix_q <= 1'b0;
      out_full <= 1'b0;
      out_data <= '0;
    end else begin
      if (out_take) out_full <= 1'b0;
      if (in_fire) begin
        if (is_prefix) begin
          prefix_q <= 1'b1;
        end else if (!lock_drop) begin
          out_data <= mapped;
          out_full <= 1'b1;
          prefix_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_cmd_engine.sv
`timescale 1ns/1ps
module kbd_cmd_engine
  import kbd_xlat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_fire,
  input  code_t in_byte,
  input  logic  out_take,
  output logic  busy,
  output logic  clear,
  output logic  out_valid,
  output code_t out_data
);
  phase_e                 phase;
  rsp_e                   kind;
  logic                   led_mode;
  logic [RSP_IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= RSP_IDENT;
      led_mode <= 1'b0;
      idx      <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (in_fire) begin
            if (led_mode) begin
              led_mode <= 1'b0;
            end else begin
              unique case (in_byte)
                CMD_IDENT: begin
                  kind  <= RSP_IDENT;
                  phase <= PH_CLEAR;
                end
                CMD_LAYOUT_A, CMD_LAYOUT_B: begin
                  kind  <= RSP_LAYOUT;
                  phase <= PH_CLEAR;
                end
                CMD_LEDS: led_mode <= 1'b1;
                default: ;
              endcase
            end
          end
        end
        PH_CLEAR: begin
          idx   <= '0;
          phase <= PH_EMIT;
        end
        PH_EMIT: begin
          if (out_take) begin
            if (idx == rsp_last(kind)) phase <= PH_IDLE;
            else                       idx   <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign clear     = (phase == PH_CLEAR);
  assign out_valid = (phase == PH_EMIT);
  assign out_data  = rsp_byte(kind, idx);
endmodule

// File: rtl/kbd_xlat.sv
`timescale 1ns/1ps
module kbd_xlat
  import kbd_xlat_pkg::*;
#(
  parameter logic [MAP_BITS-1:0] PRI_MAP     = build_map(37, 5),
  parameter logic [MAP_BITS-1:0] ALT_MAP     = build_map(11, 3),
  parameter logic [7:0]          PREFIX_CODE = 8'hE0,
  parameter int unsigned         NKEYS       = 2,
  parameter logic [NKEYS*8-1:0]  LOCK_PRESS  = {8'd69, 8'd58}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_valid,
  output logic       scan_ready,
  input  logic [7:0] scan_code,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  output logic       push_valid,
  input  logic       push_ready,
  output logic [7:0] push_data,
  output logic       q_clear
);
  logic  sc_full;
  code_t sc_data;
  logic  ce_busy;
  logic  ce_valid;
  code_t ce_data;
  logic  idle;
  logic  scan_fire;
  logic  cmd_fire;
  logic  take;

  // One input or outstanding output at a time; command wins a tie
  assign idle       = !ce_busy && !sc_full;
  assign cmd_ready  = idle;
  assign scan_ready = idle && !cmd_valid;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign scan_fire  = scan_valid && scan_ready;

  assign push_valid = ce_valid || sc_full;
  assign push_data  = ce_valid ? ce_data : sc_data;
  assign take       = push_valid && push_ready;

  kbd_scan_stage #(
    .PRI_MAP     (PRI_MAP),
    .ALT_MAP     (ALT_MAP),
    .PREFIX_CODE (PREFIX_CODE),
    .NKEYS       (NKEYS),
    .LOCK_PRESS  (LOCK_PRESS)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (scan_fire),
    .in_code  (scan_code),
    .out_take (take && !ce_valid),
    .out_full (sc_full),
    .out_data (sc_data)
  );

  kbd_cmd_engine u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (cmd_fire),
    .in_byte   (cmd_byte),
    .out_take  (take && ce_valid),
    .busy      (ce_busy),
    .clear     (q_clear),
    .out_valid (ce_valid),
    .out_data  (ce_data)
  );
endmodule

// File: rtl/kbd_xlat_chk.sv
`timescale 1ns/1ps
module kbd_xlat_chk #(
  parameter logic [7:0] PREFIX_CODE = 8'hE0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_valid,
  input logic       scan_ready,
  input logic [7:0] scan_code,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       push_valid,
  input logic       push_ready,
  input logic [7:0] push_data,
  input logic       q_clear
);
  AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |-> $past(cmd_valid && cmd_ready)); // R1
  AST_CLEAR_THEN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> push_valid); // R2
  AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !(cmd_byte inside {8'h01, 8'h07, 8'h0F})) |=> !q_clear); // R3
  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_ready && scan_code == PREFIX_CODE) |=> !push_valid); // R5
  AST_REPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |-> (!cmd_ready && !scan_ready)); // R8
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data))); // R9
  AST_ONE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_valid && scan_ready && cmd_valid && cmd_ready)); // R10
endmodule

bind kbd_xlat kbd_xlat_chk #(.PREFIX_CODE(PREFIX_CODE)) u_kbd_xlat_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_valid (scan_valid),
  .scan_ready (scan_ready),
  .scan_code  (scan_code),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_byte   (cmd_byte),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_data  (push_data),
  .q_clear    (q_clear)
);

// File: tb/kbd_xlat_bench.sv
`timescale 1ns/1ps
module kbd_xlat_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_valid = 1'b0;
  logic       scan_ready;
  logic [7:0] scan_code = 8'h00;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic       push_valid;
  logic       push_ready = 1'b1;
  logic [7:0] push_data;
  logic       q_clear;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Model state and logs; 256 stands for a queue-clear marker
  int    exp_v [4096];
  string exp_t [4096];
  int    ne = 0;
  int    lg [4096];
  int    nl = 0;
  bit    m_prefix = 1'b0;
  bit    m_led = 1'b0;
  int    m_lock [2] = '{0, 0};
  bit    prev_stall = 1'b0;
  logic [7:0] prev_d = 8'h00;

  always #2.5 clk = ~clk;

  kbd_xlat u_kbd_xlat (
    .clk(clk), .rst_n(rst_n),
    .scan_valid(scan_valid), .scan_ready(scan_ready), .scan_code(scan_code),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .q_clear(q_clear)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int pri_map(int i); return (37 * i + 5) % 128; endfunction
  function automatic int alt_map(int i); return (11 * i + 3) % 128; endfunction

  task automatic expect_byte(input int v, input string tag);
    exp_v[ne] = v; exp_t[ne] = tag; ne++;
  endtask

  // Monitor: sample away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall) check(push_valid && push_data == prev_d, "R9 hold", int'(push_data), int'(prev_d));
      if (q_clear) begin lg[nl] = 256; nl++; end
      if (push_valid && push_ready) begin lg[nl] = int'(push_data); nl++; end
      prev_stall = push_valid && !push_ready;
      prev_d     = push_data;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0:       push_ready = 1'b1;
        1:       push_ready = (cyc % 3) != 0;
        default: push_ready = 1'b0;
      endcase
    end
  end

  task automatic model_scan(input int c);
    int k;
    string tag;
    tag = m_prefix ? "R5" : "R6";
    if (c == 224) begin m_prefix = 1'b1; return; end
    k = (c == 58 || c == 186) ? 0 : (c == 69 || c == 197) ? 1 : -1;
    if (k >= 0) begin
      tag = "R7";
      if (c < 128) begin
        m_lock[k] = m_lock[k] ^ 1;
        if (m_lock[k] == 2) return;
      end else begin
        m_lock[k] = m_lock[k] ^ 2;
        if (m_lock[k] == 3) return;
      end
    end
    expect_byte((m_prefix ? alt_map(c % 128) : pri_map(c % 128)) | (c & 128), tag);
    m_prefix = 1'b0;
  endtask

  task automatic model_cmd(input int b);
    if (m_led) begin m_led = 1'b0; return; end
    case (b)
      1: begin expect_byte(256, "R1"); expect_byte(255, "R1"); expect_byte(4, "R1"); expect_byte(127, "R1"); end
      7, 15: begin expect_byte(256, "R2"); expect_byte(254, "R2"); expect_byte(0, "R2"); end
      14: m_led = 1'b1;
      default: ;
    endcase
  endtask

  task automatic send_scan(input int c);
    @(posedge clk); #1;
    scan_code = 8'(c); scan_valid = 1'b1;
    @(negedge clk);
    while (!scan_ready) @(negedge clk);
    @(posedge clk); #1;
    scan_valid = 1'b0;
  endtask

  task automatic send_cmd(input int b);
    @(posedge clk); #1;
    cmd_byte = 8'(b); cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic do_scan(input int c); model_scan(c); send_scan(c); endtask
  task automatic do_cmd(input int b);  model_cmd(b);  send_cmd(b);  endtask

  task automatic compare(input string what);
    int n;
    repeat (16) @(posedge clk);
    check(nl == ne, {what, " length R3 R4"}, nl, ne);
    n = (nl < ne) ? nl : ne;
    for (int i = 0; i < n; i++) check(lg[i] == exp_v[i], {what, " ", exp_t[i]}, lg[i], exp_v[i]);
    nl = 0; ne = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!push_valid, "R11 push_valid", int'(push_valid), 0);
    check(!q_clear,    "R11 q_clear",    int'(q_clear), 0);
    check(scan_ready,  "R11 scan_ready", int'(scan_ready), 1);
    check(cmd_ready,   "R11 cmd_ready",  int'(cmd_ready), 1);

    // R6 R7: every scancode through the primary table
    for (int c = 0; c < 256; c++) do_scan(c);
    compare("primary sweep");
    // R5: every code behind the prefix
    for (int c = 0; c < 256; c++) begin
      if (c != 224) begin do_scan(224); do_scan(c); end
    end
    compare("prefix sweep");
    // R7: lock toggling, and dropped events keep the prefix
    for (int r = 0; r < 3; r++) begin
      do_scan(58); do_scan(186); do_scan(69); do_scan(197);
    end
    for (int r = 0; r < 4; r++) begin
      do_scan(224); do_scan((r % 2 == 0) ? 58 : 186); do_scan(17);
      do_scan(224); do_scan((r % 2 == 0) ? 69 : 197); do_scan(145);
    end
    compare("lock keys");

    // R1 R2 R3 R4: all command values, in order
    for (int b = 0; b < 256; b++) do_cmd(b);
    compare("command sweep");
    // R4: parameter byte swallowed even if it is a command
    do_cmd(14); do_cmd(1); compare("led swallow");
    do_cmd(14); do_cmd(7); do_cmd(15); compare("led then layout");

    // R8: inputs blocked during a reply
    model_cmd(1); send_cmd(1);
    @(negedge clk);
    check(!cmd_ready,  "R8 cmd_ready",  int'(cmd_ready), 0);
    check(!scan_ready, "R8 scan_ready", int'(scan_ready), 0);
    compare("reply block");

    // R10: pending byte blocks inputs; command wins a tie
    rdy_mode = 2;
    do_scan(5);
    @(negedge clk);
    check(!scan_ready, "R10 scan_ready full", int'(scan_ready), 0);
    check(!cmd_ready,  "R10 cmd_ready full",  int'(cmd_ready), 0);
    rdy_mode = 0;
    compare("held byte");
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_byte = 8'h33; scan_valid = 1'b1; scan_code = 8'h10;
    @(negedge clk);
    check(!scan_ready, "R10 tie scan_ready", int'(scan_ready), 0);
    check(cmd_ready,   "R10 tie cmd_ready",  int'(cmd_ready), 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0; scan_valid = 1'b0;
    compare("tie");

    // R9: back-pressure on replies and scancodes
    rdy_mode = 1;
    do_cmd(1); do_scan(30); do_cmd(15); do_scan(224); do_scan(200);
    for (int c = 40; c < 60; c++) do_scan(c);
    compare("stall mix");
    rdy_mode = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule